// File: doc/BRIEF.md
# Pattern-Match Periodic Interrupt Timer

This block is a free-running up-counter, 48 bits wide by default, that raises an interrupt each time the count matches a programmed compare value. A per-bit mask register lets software exclude chosen bit positions from the comparison. An excluded bit always counts as equal, so a match can be defined on a bit pattern instead of one exact count. On every match the counter returns to zero, which makes the interrupt repeat with a fixed period.

Software reaches the block through a simple single-cycle register bus with 32-bit data. Every 48-bit quantity is split into a 32-bit low word and a 16-bit high word. Counting can be frozen from a debug-halt input unless software has chosen to let the timer run through halts. Reading the counter's high word latches the low word at the same instant, so a high-then-low read pair returns one consistent 48-bit value.

Top module: `pattern_match_timer`

## Requirements
- R1: After reset the control word, the mask and the counter read 0, the interrupt flag and `irq` are 0, and the compare value reads all ones (low word 0xFFFFFFFF, high word 0xFFFF).
- R2: Word addresses are 0 control (bit 0 enable, bit 1 run-during-halt), 1 flag, 2 compare low, 3 compare high, 4 mask low, 5 mask high, 6 counter low, 7 counter high. The control, compare and mask words read back what was written, and high words use data bits 15:0.
- R3: While counting is active the counter advances by one per clock. While the enable bit is 0 the counter holds its value.
- R4: A match occurs on a counting cycle when every counter bit whose mask bit is 0 equals the corresponding compare bit. Mask bits set to 1 are ignored in the comparison. When counting starts from zero, the first match therefore lands on count T = compare AND NOT mask.
- R5: On a match the counter becomes 0 on the next clock, so successive matches are T+1 clocks apart.
- R6: A match sets the interrupt flag, which then stays set. Writing 1 to flag bit 0 clears it. Writing 0 has no effect. A match in the same cycle as a clear leaves the flag set.
- R7: `irq` is high exactly when the flag is set and the enable bit is 1. Clearing the enable bit hides a pending flag without clearing it.
- R8: While `dbg_halt` is high and the run-during-halt bit is 0, the counter holds. With that bit at 1, the counter keeps advancing during a halt.
- R9: A read of the counter high word returns the live high bits and copies the live low bits into a snapshot. A later read of the counter low word returns that snapshot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dbg_halt | input | 1 | Debug halt request |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle `bus_rd` is high |
| irq | output | 1 | Interrupt request |

## Verification
The match logic is swept over every compare value from 0 to 11, crossed with five low mask patterns: none, the lowest bit, the two lowest bits, a single middle bit, and two scattered bits. One extra case masks the whole high word and most of the low word. For each case the bench predicts both the delay to the first interrupt and the repeat period from T = compare AND NOT mask. This separates an exact compare, an inverted mask and a missing clear-on-match. The T = 0 cases force a match into the same cycle as a flag clear, which shows whether set wins over clear. Counter snapshots are taken through the high-then-low read pair after known idle, halt and run-through-halt intervals, so a missing snapshot or a wrong halt gate shows up as a count that is off.

// File: rtl/pattern_match_timer.sv
module pattern_match_timer #(
  parameter int CNT_W = 48,
  parameter int LO_W  = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            dbg_halt,
  input  logic            bus_wr,
  input  logic            bus_rd,
  input  logic [2:0]      bus_addr,
  input  logic [LO_W-1:0] bus_wdata,
  output logic [LO_W-1:0] bus_rdata,
  output logic            irq
);
  localparam int HI_W = CNT_W - LO_W;
  localparam logic [2:0] A_CTRL = 3'd0, A_FLAG = 3'd1, A_CMPL = 3'd2, A_CMPH = 3'd3,
                         A_MSKL = 3'd4, A_MSKH = 3'd5, A_CNTL = 3'd6, A_CNTH = 3'd7;

  logic [CNT_W-1:0] cnt, cmp, msk;
  logic [LO_W-1:0]  snap;
  logic             en, run_halt, flag;

  wire counting = en && (run_halt || !dbg_halt);
  wire match    = counting && (((cnt ^ cmp) & ~msk) == '0);
  wire clr_wr   = bus_wr && bus_addr == A_FLAG && bus_wdata[0];

  assign irq = flag && en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en <= 1'b0;
      run_halt <= 1'b0;
      cmp <= '1;
      msk <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        A_CTRL: begin en <= bus_wdata[0]; run_halt <= bus_wdata[1]; end
        A_CMPL: cmp[LO_W-1:0] <= bus_wdata;
        A_CMPH: cmp[CNT_W-1:LO_W] <= bus_wdata[HI_W-1:0];
        A_MSKL: msk[LO_W-1:0] <= bus_wdata;
        A_MSKH: msk[CNT_W-1:LO_W] <= bus_wdata[HI_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (match)    cnt <= '0;
    else if (counting) cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag <= 1'b0;
    else if (match)   flag <= 1'b1;
    else if (clr_wr)  flag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          snap <= '0;
    else if (bus_rd && bus_addr == A_CNTH) snap <= cnt[LO_W-1:0];
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL: bus_rdata = {{(LO_W-2){1'b0}}, run_halt, en};
      A_FLAG: bus_rdata = {{(LO_W-1){1'b0}}, flag};
      A_CMPL: bus_rdata = cmp[LO_W-1:0];
      A_CMPH: bus_rdata = {{(LO_W-HI_W){1'b0}}, cmp[CNT_W-1:LO_W]};
      A_MSKL: bus_rdata = msk[LO_W-1:0];
      A_MSKH: bus_rdata = {{(LO_W-HI_W){1'b0}}, msk[CNT_W-1:LO_W]};
      A_CNTL: bus_rdata = snap;
      A_CNTH: bus_rdata = {{(LO_W-HI_W){1'b0}}, cnt[CNT_W-1:LO_W]};
      default: ;
    endcase
  end

  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    counting && !match |=> cnt == $past(cnt) + 1'b1);
  p_hold_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(cnt));
  p_halt_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
    en && dbg_halt && !run_halt |=> $stable(cnt));
  p_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> cnt == '0);
  p_flag_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> flag);
  p_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    flag && !clr_wr |=> flag);
  p_irq_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !irq);
endmodule

// File: tb/pattern_match_timer_tb_top.sv
module pattern_match_timer_tb_top;
  logic clk = 0, rst_n = 0, dbg_halt = 0, bus_wr = 0, bus_rd = 0;
  logic [2:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic irq;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pattern_match_timer dut_i (.clk(clk), .rst_n(rst_n), .dbg_halt(dbg_halt), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 0; dbg_halt = 0; bus_wr = 0; bus_rd = 0;
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    bus_rd = 1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 0;
  endtask

  task automatic wait_irq(output int n);
    n = 0;
    while (!irq && n < 200) begin @(negedge clk); n++; end
  endtask

  task automatic run_case(input int c, input int m, input logic [31:0] chi, input logic [31:0] mhi);
    int n, t;
    logic [31:0] d;
    t = c & ~m;
    do_reset();
    wr(3'd2, c); wr(3'd3, chi); wr(3'd4, m); wr(3'd5, mhi);
    wr(3'd0, 32'd1);
    wait_irq(n);
    chk($sformatf("R4 first match c=%0d m=%0h", c, m), n, t + 1);
    wr(3'd1, 32'd1);
    n = 1;
    while (!irq && n < 200) begin @(negedge clk); n++; end
    chk($sformatf("R5 R6 period c=%0d m=%0h", c, m), n, t + 1);
    if (t > 2) begin
      wr(3'd0, 32'd0);
      chk("R7 irq hidden when disabled", irq, 0);
      rd(3'd1, d); chk("R7 flag kept pending", d, 1);
      wr(3'd1, 32'd0);
      rd(3'd1, d); chk("R6 write 0 ignored", d, 1);
      wr(3'd1, 32'd1);
      rd(3'd1, d); chk("R6 write 1 clears", d, 0);
    end
  endtask

  initial begin
    #(4 * 200000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    if (!done) begin
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int masks[5] = '{0, 1, 3, 4, 9};
    do_reset();
    // R1 reset state
    chk("R1 irq", irq, 0);
    rd(3'd0, d); chk("R1 ctrl", d, 0);
    rd(3'd1, d); chk("R1 flag", d, 0);
    rd(3'd2, d); chk("R1 cmp lo", d, 32'hFFFF_FFFF);
    rd(3'd3, d); chk("R1 cmp hi", d, 32'h0000_FFFF);
    rd(3'd4, d); chk("R1 mask lo", d, 0);
    rd(3'd5, d); chk("R1 mask hi", d, 0);
    rd(3'd7, d); chk("R1 cnt hi", d, 0);
    rd(3'd6, d); chk("R1 cnt lo", d, 0);
    // R2 readback
    wr(3'd2, 32'h1234_5678); rd(3'd2, d); chk("R2 cmp lo", d, 32'h1234_5678);
    wr(3'd3, 32'hABCD_9876); rd(3'd3, d); chk("R2 cmp hi", d, 32'h9876);
    wr(3'd4, 32'h0F0F_0F0F); rd(3'd4, d); chk("R2 mask lo", d, 32'h0F0F_0F0F);
    wr(3'd5, 32'hFFFF_FFFF); rd(3'd5, d); chk("R2 mask hi", d, 32'hFFFF);
    wr(3'd0, 32'd2); rd(3'd0, d); chk("R2 ctrl", d, 2);
    // R3 R8 R9 counting, halt and snapshot with no match possible
    do_reset();
    wr(3'd0, 32'd1);
    repeat (10) @(negedge clk);
    rd(3'd7, d); chk("R9 cnt hi", d, 0);
    repeat (3) @(negedge clk);
    rd(3'd6, d); chk("R3 R9 snapshot low", d, 10);
    wr(3'd0, 32'd0);
    repeat (5) @(negedge clk);
    rd(3'd7, d); rd(3'd6, d); chk("R3 hold when disabled", d, 16);
    do_reset();
    wr(3'd0, 32'd1);
    repeat (5) @(negedge clk);
    dbg_halt = 1;
    repeat (7) @(negedge clk);
    rd(3'd7, d); rd(3'd6, d); chk("R8 frozen during halt", d, 5);
    wr(3'd0, 32'd3);
    repeat (4) @(negedge clk);
    rd(3'd7, d); rd(3'd6, d); chk("R8 runs through halt", d, 9);
    dbg_halt = 0;
    // R4 R5 R6 sweep over compare and mask
    for (int c = 0; c < 12; c++)
      for (int k = 0; k < 5; k++)
        run_case(c, masks[k], 32'd0, 32'd0);
    run_case(32'hFFFF_FFF6, 32'hFFFF_FFF0, 32'hFFFF, 32'hFFFF);
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule